// File: doc/BRIEF.md
# Banked GPIO Port Controller

This block is a register-mapped general-purpose I/O controller. It serves several ports of sixteen pins each, and all of them sit behind a simple synchronous register bus. For every pin, software sets the level to drive, whether the pin is an input or an output, and whether the pin is in plain GPIO mode or handed to a peripheral. Software also sets whether the pin's input buffer is on. The live pin level is read back through a two-stage synchronizer.

The data, direction and mode registers each have a second address, a masked-set alias. A 32-bit write to an alias carries per-bit write enables in its upper half. Software can therefore change a single pin without a read-modify-write, and a pin can be given its output level before it is turned into an output. Each register group has a fixed base offset, and the port within the group is chosen by a four-byte stride taken from address bits [3:2].

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every pin is an input (direction 0xFFFF) in GPIO mode (mode 0), with output data 0 and input buffer 0. pin_oe and pin_out are all zero.
- R2: A write to a direct register stores the low 16 bits of the write data. A read returns the value in bits [15:0] and zero in bits [31:16]. The direct registers are output data at 0x000, direction at 0x300, mode at 0x400 and input-buffer enable at 0x4000, each plus 4 times the port index.
- R3: A write to a masked alias loads bit n from wdata[n] only where wdata[n+16] is 1. Every other bit keeps its value. The aliases are output data at 0x100, direction at 0x800 and mode at 0x900.
- R4: pin_oe for a pin is 1 exactly when its direction bit is 0 (output) and its mode bit is 0 (GPIO).
- R5: pin_out for a pin equals its output data bit.
- R6: Reading 0x200 plus 4 times the port index returns the pin levels in bits [15:0], gated by the input-buffer enable bits. A pin whose buffer is off reads 0. A change on pin_in is not visible after one rising edge and is visible after two.
- R7: A read of a masked alias returns the current register value in bits [15:0] and zero in bits [31:16].
- R8: The following all read as zero and ignore writes: offsets outside the listed groups, addresses with bits [1:0] or [7:4] nonzero, and port indices at or above NUM_BANKS. Writes to the readback register have no effect.
- R9: A write to one port changes only that port's pins. Port b owns pin bits [16b+15:16b].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data; upper half is the per-bit enable for aliases |
| bus_rdata | output | 32 | Read data, combinational from address and state |
| pin_in | input | 16*NUM_BANKS | Pin input levels |
| pin_out | output | 16*NUM_BANKS | Pin output levels |
| pin_oe | output | 16*NUM_BANKS | Pin output enables |

## Verification
The hardest cases to reach from the ports involve the synchronizer delay on readback. The bench changes pin_in just after a rising edge, reads once after the next edge and expects the old level, then reads again after another edge and expects the new level. The second hard case is the input-buffer gate, which masks that level. The bench holds a fixed pattern on a port, reads it with the buffers off, then with half of them on, then with all of them on. Isolation between ports is shown by writing to one port and then checking the pins and readback of the other ports.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PORT_W = 16;

    typedef enum logic [3:0] {
        K_NONE,
        K_OUT,
        K_OUTM,
        K_PIN,
        K_DIR,
        K_MODE,
        K_DIRM,
        K_MODEM,
        K_IBE
    } reg_kind_e;

    typedef struct packed {
        logic [PORT_W-1:0] dout;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] mode;
        logic [PORT_W-1:0] ibe;
    } bank_regs_t;

    function automatic logic [PORT_W-1:0] masked_merge(
        input logic [PORT_W-1:0] cur,
        input logic [2*PORT_W-1:0] wd
    );
        logic [PORT_W-1:0] en;
        en = wd[2*PORT_W-1:PORT_W];
        return (cur & ~en) | (wd[PORT_W-1:0] & en);
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int NUM_BANKS = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [1:0]        bank,
    output logic              hit
);

    int unsigned grp;
    logic        fmt_ok;
    reg_kind_e   kind_raw;

    always_comb begin
        grp    = 32'(addr[ADDR_W-1:8]);
        fmt_ok = (addr[7:4] == 4'h0) && (addr[1:0] == 2'b00)
                 && (32'(addr[3:2]) < NUM_BANKS);
        case (grp)
            32'h00:  kind_raw = K_OUT;
            32'h01:  kind_raw = K_OUTM;
            32'h02:  kind_raw = K_PIN;
            32'h03:  kind_raw = K_DIR;
            32'h04:  kind_raw = K_MODE;
            32'h08:  kind_raw = K_DIRM;
            32'h09:  kind_raw = K_MODEM;
            32'h40:  kind_raw = K_IBE;
            default: kind_raw = K_NONE;
        endcase
        kind = fmt_ok ? kind_raw : K_NONE;
        hit  = (kind != K_NONE);
        bank = addr[3:2];
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  reg_kind_e           kind,
    input  logic [2*PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0]   pin_lvl,
    output logic [PORT_W-1:0]   rd_val,
    output logic [PORT_W-1:0]   pin_out,
    output logic [PORT_W-1:0]   pin_oe
);

    localparam bank_regs_t RESET_VAL = '{
        dout: '0,
        dir:  '1,
        mode: '0,
        ibe:  '0
    };

    bank_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (kind)
                K_OUT:   regs_d.dout = wdata[PORT_W-1:0];
                K_OUTM:  regs_d.dout = masked_merge(regs_q.dout, wdata);
                K_DIR:   regs_d.dir  = wdata[PORT_W-1:0];
                K_DIRM:  regs_d.dir  = masked_merge(regs_q.dir, wdata);
                K_MODE:  regs_d.mode = wdata[PORT_W-1:0];
                K_MODEM: regs_d.mode = masked_merge(regs_q.mode, wdata);
                K_IBE:   regs_d.ibe  = wdata[PORT_W-1:0];
                default: regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RESET_VAL;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (kind)
            K_OUT, K_OUTM:   rd_val = regs_q.dout;
            K_DIR, K_DIRM:   rd_val = regs_q.dir;
            K_MODE, K_MODEM: rd_val = regs_q.mode;
            K_IBE:           rd_val = regs_q.ibe;
            K_PIN:           rd_val = pin_lvl & regs_q.ibe;
            default:         rd_val = '0;
        endcase
    end

    assign pin_out = regs_q.dout;
    assign pin_oe  = ~regs_q.dir & ~regs_q.mode;

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int NUM_BANKS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic [NUM_BANKS*PORT_W-1:0] pin_in,
    output logic [NUM_BANKS*PORT_W-1:0] pin_out,
    output logic [NUM_BANKS*PORT_W-1:0] pin_oe
);

    localparam int TOTAL_PINS = NUM_BANKS * PORT_W;

    reg_kind_e              kind;
    logic [1:0]             bank;
    logic                   hit;
    logic [TOTAL_PINS-1:0]  pin_sync;
    logic [PORT_W-1:0]      rd_val [NUM_BANKS];

    gpio_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .bank (bank),
        .hit  (hit)
    );

    gpio_in_sync #(
        .WIDTH (TOTAL_PINS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic we;
        assign we = bus_sel && bus_wr && hit && (32'(bank) == b);

        gpio_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (we),
            .kind    (kind),
            .wdata   (bus_wdata),
            .pin_lvl (pin_sync[b*PORT_W +: PORT_W]),
            .rd_val  (rd_val[b]),
            .pin_out (pin_out[b*PORT_W +: PORT_W]),
            .pin_oe  (pin_oe[b*PORT_W +: PORT_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_sel && !bus_wr && hit && (32'(bank) == b))
                bus_rdata = {16'h0000, rd_val[b]};
        end
    end

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
    parameter int ADDR_W    = 15,
    parameter int NUM_BANKS = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_sel,
    input logic                        bus_wr,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [31:0]                 bus_wdata,
    input logic [31:0]                 bus_rdata,
    input logic [NUM_BANKS*16-1:0]     pin_out,
    input logic [NUM_BANKS*16-1:0]     pin_oe
);

    logic wr_out_alias0, wr_dir0, rd_alias, rd_undef;

    assign wr_out_alias0 = bus_sel && bus_wr && (bus_addr == ADDR_W'(12'h100));
    assign wr_dir0       = bus_sel && bus_wr && (bus_addr == ADDR_W'(12'h300));
    assign rd_alias      = bus_sel && !bus_wr &&
                           ((bus_addr == ADDR_W'(12'h100)) ||
                            (bus_addr == ADDR_W'(12'h800)) ||
                            (bus_addr == ADDR_W'(12'h900)));
    assign rd_undef      = bus_sel && !bus_wr && (bus_addr == ADDR_W'(16'h1000));

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_out_alias0 && bus_wdata[31:16] == 16'h0000) |=> $stable(pin_out[15:0])); // R3

    AST_MASK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_out_alias0 && bus_wdata[31:16] == 16'hFFFF) |=> (pin_out[15:0] == $past(bus_wdata[15:0]))); // R3

    AST_ALL_INPUT_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dir0 && bus_wdata[15:0] == 16'hFFFF) |=> (pin_oe[15:0] == 16'h0000)); // R4

    AST_ALIAS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_alias |-> (bus_rdata[31:16] == 16'h0000)); // R7

    AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_undef |-> (bus_rdata == 32'h0)); // R8

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;

    localparam int ADDR_W = 15;
    localparam int NB     = 3;
    localparam int NP     = NB * 16;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              bus_sel = 0;
    logic              bus_wr = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     pin_in = '0;
    logic [NP-1:0]     pin_out;
    logic [NP-1:0]     pin_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    gpio_port_ctrl #(.ADDR_W(ADDR_W), .NUM_BANKS(NB)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    // monitor: compares read data against queued expectations
    always @(negedge clk) begin
        if (bus_sel && !bus_wr) begin
            if (exp_q.size() == 0) begin
                check("monitor unexpected read", 32'h1, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, bus_rdata, e);
            end
        end
    end

    task automatic pins(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
        @(negedge clk);
        check(tag, 32'(act[31:0]) ^ 32'(exp[31:0]) | {16'h0, act[47:32] ^ exp[47:32]}, 32'h0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 pin_oe", 32'(pin_oe[31:0]) | {16'h0, pin_oe[47:32]}, 32'h0);
        check("R1 pin_out", 32'(pin_out[31:0]) | {16'h0, pin_out[47:32]}, 32'h0);
        bus_read(15'h300, 32'h0000FFFF, "R1 dir reset");
        bus_read(15'h400, 32'h0, "R1 mode reset");
        bus_read(15'h4000, 32'h0, "R1 ibe reset");
        bus_read(15'h000, 32'h0, "R1 out reset");

        // R2 direct write, upper half dropped
        bus_write(15'h000, 32'h1234A5C3);
        bus_read(15'h000, 32'h0000A5C3, "R2 out direct");
        pins("R5 pin_out bank0", pin_out, {32'h0, 16'hA5C3});

        // R3 masked output: low byte enabled only
        bus_write(15'h100, 32'h00FF003C);
        bus_read(15'h000, 32'h0000A53C, "R3 masked out");
        bus_read(15'h100, 32'h0000A53C, "R7 alias read");
        bus_write(15'h100, 32'h0000FFFF);
        bus_read(15'h000, 32'h0000A53C, "R3 zero enable keeps");

        // R4 direction/mode gating of output enable
        bus_write(15'h800, 32'h000F0000);
        bus_read(15'h300, 32'h0000FFF0, "R3 masked dir");
        pins("R4 oe after dir clear", pin_oe, {32'h0, 16'h000F});
        bus_write(15'h900, 32'h00010001);
        pins("R4 oe with mode bit", pin_oe, {32'h0, 16'h000E});
        bus_read(15'h900, 32'h00000001, "R7 mode alias read");
        bus_write(15'h400, 32'h0);
        pins("R4 oe mode direct clear", pin_oe, {32'h0, 16'h000F});

        // R6 readback gating and sync latency on bank1
        pin_in[31:16] = 16'hBEEF;
        repeat (3) @(posedge clk);
        bus_read(15'h204, 32'h0, "R6 buffer off");
        bus_write(15'h4004, 32'h0000FF00);
        bus_read(15'h204, 32'h0000BE00, "R6 half buffer");
        bus_write(15'h4004, 32'h0000FFFF);
        bus_read(15'h204, 32'h0000BEEF, "R6 full buffer");
        pin_in[31:16] = 16'h1234;
        bus_read(15'h204, 32'h0000BEEF, "R6 one edge old");
        bus_read(15'h204, 32'h00001234, "R6 two edges new");

        // R9 bank isolation
        bus_write(15'h008, 32'h0000FFFF);
        bus_write(15'h308, 32'h0);
        pins("R9 bank2 drive", pin_out, {16'hFFFF, 16'h0000, 16'hA53C});
        pins("R9 bank2 oe", pin_oe, {16'hFFFF, 16'h0000, 16'h000F});
        bus_read(15'h200, 32'h0, "R9 bank0 readback untouched");

        // R8 undefined and ignored accesses
        bus_write(15'h1000, 32'hFFFFFFFF);
        bus_read(15'h1000, 32'h0, "R8 undefined read");
        bus_write(15'h200, 32'h0000FFFF);
        bus_read(15'h000, 32'h0000A53C, "R8 readback write ignored");
        bus_read(15'h204, 32'h00001234, "R8 readback value kept");
        bus_write(15'h002, 32'h0000FFFF);
        bus_read(15'h002, 32'h0, "R8 unaligned read");
        bus_read(15'h000, 32'h0000A53C, "R8 unaligned write ignored");
        bus_write(15'h30C, 32'h0);
        bus_read(15'h30C, 32'h0, "R8 bank out of range");
        pins("R8 oe unchanged", pin_oe, {16'hFFFF, 16'h0000, 16'h000F});

        repeat (3) @(posedge clk);
        check("monitor queue drained", 32'(exp_q.size()), 32'h0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule